// File: doc/BRIEF.md
# Scan Cycle Supervisor

This block oversees the repeating program scan of a small logic controller. It does not run instructions or move bus data. It decides when the controller may take part on its bus, and it reports faults. After power becomes good, it waits a fixed readiness delay. It then runs an initialization phase lasting a fixed number of scan ticks, with the function-block init enable raised. A further hold-off phase follows, also counted in scan ticks. Bus outputs stay frozen through all of these phases.

Once running, each scan tick opens a new scan, but only if the previous scan has already delivered its end strobe. A scan that fails to end within the watchdog limit trips an overrun fault. The trip freezes the bus outputs for a lockout time and raises the internal fault and the alarm. The fault clears when a later scan ends on time after the lockout has expired.

Three events restart the whole sequence:
- loss of power-good,
- a disturbed bus address,
- a switch of program memory source.

A simulation flag feeds the device fault output alongside the internal fault. All times are counted in clock cycles, and all phase lengths in scan ticks, both set by parameters.

Top module: `scan_supervisor`

## Requirements
- R1: While `pwr_ok` is low, `out_freeze` is high and `fb_init` and `int_fault` are low. Once `pwr_ok` is high, `fb_init` first goes high after the (READY_CLKS+1)-th rising edge that samples `pwr_ok` high.
- R2: During initialization, `fb_init` and `out_freeze` are both high. `fb_init` falls at the INIT_SCANS-th `cyc_tick` of the phase. Clock edges without a tick change nothing.
- R3: During the hold-off phase that follows, `fb_init` is low and `out_freeze` stays high. `out_freeze` falls at the HOLD_SCANS-th `cyc_tick` of the phase. Outside the run phase, `out_freeze` is never low.
- R4: In the run phase, a `cyc_tick` starts a scan only when no scan is open. A tick that arrives while a scan is open is ignored and does not restart the watchdog.
- R5: Count edges from the edge that starts a scan. A scan whose `prog_end` is sampled at edge k, with k ≤ WD_CLKS, is on time. Otherwise, after edge WD_CLKS, `int_fault`, `alarm` and `out_freeze` are high.
- R6: After a trip at edge T, `out_freeze` stays high through edge T+LOCK_CLKS-1 and is low from edge T+LOCK_CLKS onward, unless the watchdog trips again. A later scan is reopened only after the stalled scan's `prog_end`.
- R7: The overrun fault stays set until a scan ends on time at an edge E ≥ T+LOCK_CLKS+1. At that edge, `int_fault` and `alarm` fall.
- R8: `addr_bad` high, or a one-clock `mem_switch` pulse, gives the following on the next cycle: `out_freeze` and `int_fault` high, `fb_init` low, and any overrun state cleared. On the cycle after the condition is gone, initialization restarts from its first tick.
- R9: `dev_fault` is high exactly when `int_fault` or `sim_on` is high. `sim_on` has no effect on `out_freeze`, `int_fault` or `alarm`. `alarm` always equals `int_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_tick | input | 1 | One-clock strobe marking the start of a scan period |
| prog_end | input | 1 | One-clock strobe: the running scan reached its end mark |
| pwr_ok | input | 1 | Supply good level |
| addr_bad | input | 1 | Bus address disturbed level |
| mem_switch | input | 1 | One-clock pulse: program memory source switched |
| sim_on | input | 1 | Bus simulation active level |
| out_freeze | output | 1 | Latch bus outputs at their last values |
| fb_init | output | 1 | Function-block initialization enable |
| int_fault | output | 1 | Internal fault (overrun or disturbance) |
| dev_fault | output | 1 | Device fault: internal fault or simulation |
| alarm | output | 1 | Alarm indicator |

## Verification
The assertions assume the following about the inputs:
- All inputs are synchronous to `clk`.
- `cyc_tick`, `prog_end` and `mem_switch` are single-cycle strobes.
- `prog_end` comes only while a scan is open.

The stimulus changes inputs two time units after each rising edge. It pulses the strobes for exactly one clock. It always closes a scan before ticking again, except in the one directed case that fires an extra tick into an open scan to show that the tick is ignored. Random scan lengths cover both sides of the watchdog limit, and random gaps fall across the lockout expiry.

// File: rtl/scs_pkg.sv
package scs_pkg;

  typedef enum logic [2:0] {
    PH_OFF  = 3'd0,
    PH_RDY  = 3'd1,
    PH_DIST = 3'd2,
    PH_INIT = 3'd3,
    PH_HOLD = 3'd4,
    PH_RUN  = 3'd5
  } phase_e;

  // largest of three counts, used to size the shared phase counter
  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // true when a counter holding cnt has reached the final step of lim
  function automatic logic at_last(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) == lim;
  endfunction

  // watchdog fires on the edge where elapsed count reaches the limit with no end mark
  function automatic logic wd_due(input logic busy, input logic late, input logic done,
                                  input int unsigned elapsed, input int unsigned lim);
    return busy && !late && !done && ((elapsed + 1) == lim);
  endfunction

endpackage

// File: rtl/scs_phase_seq.sv
module scs_phase_seq
  import scs_pkg::*;
#(
  parameter int unsigned READY_CLKS = 50,
  parameter int unsigned INIT_SCANS = 35,
  parameter int unsigned HOLD_SCANS = 10
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwr_ok,
  input  logic   addr_bad,
  input  logic   mem_switch,
  input  logic   cyc_tick,
  output phase_e phase
);

  localparam int unsigned MAXC = max3(READY_CLKS, INIT_SCANS, HOLD_SCANS);
  localparam int CW = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  phase_e        phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
    end else if (!pwr_ok) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
    end else if (addr_bad || mem_switch) begin
      phase_q <= PH_DIST;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_OFF: begin
          phase_q <= PH_RDY;
          cnt_q   <= '0;
        end
        PH_RDY: begin
          if (at_last(32'(cnt_q), READY_CLKS)) begin
            phase_q <= PH_INIT;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_DIST: begin
          phase_q <= PH_INIT;
          cnt_q   <= '0;
        end
        PH_INIT: begin
          if (cyc_tick) begin
            if (at_last(32'(cnt_q), INIT_SCANS)) begin
              phase_q <= PH_HOLD;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        PH_HOLD: begin
          if (cyc_tick) begin
            if (at_last(32'(cnt_q), HOLD_SCANS)) begin
              phase_q <= PH_RUN;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        PH_RUN: begin
          cnt_q <= '0;
        end
        default: begin
          phase_q <= PH_OFF;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/scs_scan_wd.sv
module scs_scan_wd
  import scs_pkg::*;
#(
  parameter int unsigned WD_CLKS   = 60,
  parameter int unsigned LOCK_CLKS = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_run,
  input  logic cyc_tick,
  input  logic prog_end,
  output logic ovr_fault,
  output logic lock_on
);

  localparam int WW = $clog2(WD_CLKS + 1);
  localparam int LW = $clog2(LOCK_CLKS + 1);

  logic          busy_q;
  logic          late_q;
  logic [WW-1:0] wd_q;
  logic [LW-1:0] lock_q;
  logic          ovr_q;

  logic scan_start;
  logic scan_done;
  logic on_time_done;
  logic wd_trip;

  assign scan_start   = in_run && cyc_tick && !busy_q;
  assign scan_done    = busy_q && prog_end;
  assign on_time_done = scan_done && !late_q;
  assign wd_trip      = wd_due(busy_q, late_q, prog_end, 32'(wd_q), WD_CLKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      late_q <= 1'b0;
      wd_q   <= '0;
      lock_q <= '0;
      ovr_q  <= 1'b0;
    end else if (!in_run) begin
      busy_q <= 1'b0;
      late_q <= 1'b0;
      wd_q   <= '0;
      lock_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (scan_start) begin
        busy_q <= 1'b1;
        late_q <= 1'b0;
        wd_q   <= '0;
      end else if (busy_q) begin
        if (scan_done) begin
          busy_q <= 1'b0;
          late_q <= 1'b0;
        end else if (wd_trip) begin
          late_q <= 1'b1;
        end
        if (wd_q != WW'(WD_CLKS)) wd_q <= wd_q + 1'b1;
      end

      if (wd_trip)           lock_q <= LW'(LOCK_CLKS);
      else if (lock_q != '0) lock_q <= lock_q - 1'b1;

      if (wd_trip)                            ovr_q <= 1'b1;
      else if (on_time_done && lock_q == '0) ovr_q <= 1'b0;
    end
  end

  assign ovr_fault = ovr_q;
  assign lock_on   = (lock_q != '0);

endmodule

// File: rtl/scs_fault_out.sv
module scs_fault_out
  import scs_pkg::*;
(
  input  phase_e phase,
  input  logic   ovr_fault,
  input  logic   lock_on,
  input  logic   sim_on,
  output logic   out_freeze,
  output logic   fb_init,
  output logic   int_fault,
  output logic   dev_fault,
  output logic   alarm
);

  logic running;
  logic disturbed;
  logic fault_any;

  always_comb begin
    running    = (phase == PH_RUN);
    disturbed  = (phase == PH_DIST);
    fault_any  = disturbed || (running && ovr_fault);
    out_freeze = !running || lock_on;
    fb_init    = (phase == PH_INIT);
    int_fault  = fault_any;
    alarm      = fault_any;
    dev_fault  = fault_any || sim_on;
  end

endmodule

// File: rtl/scan_supervisor.sv
module scan_supervisor
  import scs_pkg::*;
#(
  parameter int unsigned READY_CLKS = 50,
  parameter int unsigned INIT_SCANS = 35,
  parameter int unsigned HOLD_SCANS = 10,
  parameter int unsigned WD_CLKS    = 60,
  parameter int unsigned LOCK_CLKS  = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_tick,
  input  logic prog_end,
  input  logic pwr_ok,
  input  logic addr_bad,
  input  logic mem_switch,
  input  logic sim_on,
  output logic out_freeze,
  output logic fb_init,
  output logic int_fault,
  output logic dev_fault,
  output logic alarm
);

  phase_e phase;
  logic   in_run;
  logic   ovr_fault;
  logic   lock_on;

  assign in_run = (phase == PH_RUN);

  scs_phase_seq #(
    .READY_CLKS(READY_CLKS),
    .INIT_SCANS(INIT_SCANS),
    .HOLD_SCANS(HOLD_SCANS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_ok    (pwr_ok),
    .addr_bad  (addr_bad),
    .mem_switch(mem_switch),
    .cyc_tick  (cyc_tick),
    .phase     (phase)
  );

  scs_scan_wd #(
    .WD_CLKS  (WD_CLKS),
    .LOCK_CLKS(LOCK_CLKS)
  ) u_wd (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_run   (in_run),
    .cyc_tick (cyc_tick),
    .prog_end (prog_end),
    .ovr_fault(ovr_fault),
    .lock_on  (lock_on)
  );

  scs_fault_out u_out (
    .phase     (phase),
    .ovr_fault (ovr_fault),
    .lock_on   (lock_on),
    .sim_on    (sim_on),
    .out_freeze(out_freeze),
    .fb_init   (fb_init),
    .int_fault (int_fault),
    .dev_fault (dev_fault),
    .alarm     (alarm)
  );

endmodule

// File: rtl/scan_supervisor_chk.sv
module scan_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_ok,
  input logic addr_bad,
  input logic mem_switch,
  input logic sim_on,
  input logic fb_init,
  input logic out_freeze,
  input logic int_fault,
  input logic dev_fault,
  input logic in_run
);

  AST_NOPWR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> out_freeze && !fb_init && !int_fault); // R1

  AST_INIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    fb_init |-> out_freeze); // R2

  AST_FREE_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !out_freeze |-> in_run); // R3

  AST_OVR_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_fault) && in_run |-> out_freeze); // R5

  AST_DISTURB_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_bad || mem_switch) && pwr_ok |=> out_freeze && int_fault && !fb_init); // R8

  AST_SIM_DEVFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    sim_on |-> dev_fault); // R9

  AST_INT_DEVFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    int_fault |-> dev_fault); // R9

endmodule

bind scan_supervisor scan_supervisor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_ok    (pwr_ok),
  .addr_bad  (addr_bad),
  .mem_switch(mem_switch),
  .sim_on    (sim_on),
  .fb_init   (fb_init),
  .out_freeze(out_freeze),
  .int_fault (int_fault),
  .dev_fault (dev_fault),
  .in_run    (in_run)
);

// File: tb/sim_scan_supervisor.sv
module sim_scan_supervisor;

  localparam int RDY  = 50;
  localparam int INI  = 35;
  localparam int HLD  = 10;
  localparam int WD   = 60;
  localparam int LCK  = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_tick = 1'b0;
  logic prog_end = 1'b0;
  logic pwr_ok = 1'b0;
  logic addr_bad = 1'b0;
  logic mem_switch = 1'b0;
  logic sim_on = 1'b0;
  logic out_freeze, fb_init, int_fault, dev_fault, alarm;

  int     n_chk = 0;
  int     n_bad = 0;
  longint ecnt = 0;

  // bench model of the overrun state
  logic   m_fault = 1'b0;
  logic   m_tv = 1'b0;
  longint m_trip = 0;

  always #4 clk = ~clk;
  always @(posedge clk) ecnt <= ecnt + 1;

  scan_supervisor #(
    .READY_CLKS(RDY), .INIT_SCANS(INI), .HOLD_SCANS(HLD),
    .WD_CLKS(WD), .LOCK_CLKS(LCK)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .prog_end(prog_end),
    .pwr_ok(pwr_ok), .addr_bad(addr_bad), .mem_switch(mem_switch), .sim_on(sim_on),
    .out_freeze(out_freeze), .fb_init(fb_init), .int_fault(int_fault),
    .dev_fault(dev_fault), .alarm(alarm)
  );

  function automatic logic exp_freeze(input longint e);
    return m_tv && (e < m_trip + LCK);
  endfunction

  function automatic logic clears_at(input longint e);
    return m_tv && (e >= m_trip + LCK + 1);
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at edge %0d", req, what, act, exp, ecnt);
    end
  endtask

  task automatic outs(input string req, input logic fz, input logic fi, input logic fl);
    chk(req, "out_freeze", out_freeze, fz);
    chk(req, "fb_init", fb_init, fi);
    chk(req, "int_fault", int_fault, fl);
    chk("R9", "alarm", alarm, fl);
    chk("R9", "dev_fault", dev_fault, fl | sim_on);
  endtask

  task automatic clk1();
    @(posedge clk);
    #2;
  endtask

  task automatic tick1();
    cyc_tick = 1'b1;
    clk1();
    cyc_tick = 1'b0;
  endtask

  task automatic model_clear();
    m_fault = 1'b0;
    m_tv    = 1'b0;
  endtask

  task automatic bring_up();
    pwr_ok = 1'b1;
    for (int i = 1; i <= RDY + 1; i++) begin
      clk1();
      if (i <= RDY) outs("R1", 1'b1, 1'b0, 1'b0);
      else          outs("R1", 1'b1, 1'b1, 1'b0);
    end
  endtask

  task automatic init_seq();
    for (int i = 1; i <= INI; i++) begin
      tick1();
      outs("R2", 1'b1, (i < INI), 1'b0);
      clk1();
      clk1();
      outs("R2", 1'b1, (i < INI), 1'b0);
    end
    for (int i = 1; i <= HLD; i++) begin
      tick1();
      outs("R3", (i < HLD), 1'b0, 1'b0);
      clk1();
      outs("R3", (i < HLD), 1'b0, 1'b0);
    end
    model_clear();
  endtask

  // one scan of length d edges; extra tick fired at offset xt (0 = none)
  task automatic scan(input int d, input int xt);
    longint st;
    tick1();
    st = ecnt;
    for (int j = 1; j <= d; j++) begin
      prog_end = (j == d);
      cyc_tick = (j == xt && j != d);
      clk1();
      prog_end = 1'b0;
      cyc_tick = 1'b0;
      if (j == WD - 1 && d > WD) chk("R4", "int_fault before limit", int_fault, m_fault);
      if (j == WD && d > WD) begin
        m_fault = 1'b1;
        m_tv    = 1'b1;
        m_trip  = st + WD;
        chk("R5", "int_fault at limit", int_fault, 1'b1);
        chk("R5", "out_freeze at limit", out_freeze, 1'b1);
        chk("R5", "alarm at limit", alarm, 1'b1);
      end
    end
    if (d <= WD && m_fault && clears_at(ecnt)) m_fault = 1'b0;
    outs("R7", exp_freeze(ecnt), 1'b0, m_fault);
  endtask

  task automatic gap(input int n);
    for (int k = 0; k < n; k++) begin
      clk1();
      outs("R6", exp_freeze(ecnt), 1'b0, m_fault);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd24601));
    repeat (3) @(posedge clk);
    #2;
    outs("R1", 1'b1, 1'b0, 1'b0);
    rst_n = 1'b1;
    clk1();
    clk1();
    outs("R1", 1'b1, 1'b0, 1'b0);

    bring_up();
    init_seq();

    // R4: an extra tick inside an open scan must not restart the watchdog
    scan(10, 0);
    scan(WD + 5, 20);
    gap(3);
    // R5 boundary cases
    scan(WD, 0);
    gap(2);
    scan(WD + 1, 0);
    gap(2);
    scan(5, 0);
    gap(LCK);
    scan(5, 0);

    // random scans across the limit and the lockout window
    for (int n = 0; n < 70; n++) begin
      sim_on = $urandom_range(0, 3) == 0;
      scan($urandom_range(1, WD + 15), 0);
      gap($urandom_range(0, 8));
    end

    // R9: simulation alone raises only the device fault
    sim_on = 1'b0;
    gap(LCK + 2);
    scan(4, 0);
    scan(4, 0);
    sim_on = 1'b1;
    clk1();
    outs("R9", 1'b0, 1'b0, 1'b0);
    chk("R9", "dev_fault from sim", dev_fault, 1'b1);
    sim_on = 1'b0;
    clk1();
    chk("R9", "dev_fault idle", dev_fault, 1'b0);

    // R8: memory source switch pulse
    scan(WD + 3, 0);
    mem_switch = 1'b1;
    clk1();
    mem_switch = 1'b0;
    outs("R8", 1'b1, 1'b0, 1'b1);
    clk1();
    outs("R8", 1'b1, 1'b1, 1'b0);
    init_seq();
    scan(8, 0);

    // R8: address disturbance held for several clocks
    addr_bad = 1'b1;
    for (int k = 0; k < 5; k++) begin
      clk1();
      outs("R8", 1'b1, 1'b0, 1'b1);
    end
    addr_bad = 1'b0;
    clk1();
    outs("R8", 1'b1, 1'b1, 1'b0);
    init_seq();
    scan(7, 0);

    // R1: power loss and recovery
    pwr_ok = 1'b0;
    clk1();
    outs("R1", 1'b1, 1'b0, 1'b0);
    clk1();
    outs("R1", 1'b1, 1'b0, 1'b0);
    bring_up();
    init_seq();
    scan(WD, 0);
    outs("R5", 1'b0, 1'b0, 1'b0);

    summary();
    $finish;
  end

endmodule